// File: doc/BRIEF.md
# Receive-Buffer Hysteresis Flow Controller

This block sits beside a 64-entry receive buffer of a serial port and tells the far end when to pause and when to continue sending. It compares the buffer's fill count with two programmable marks. Reaching the upper ("stop") mark puts it in a paused state. Falling to the lower ("go") mark takes it out again. Between the marks it keeps its last decision, so the line does not chatter while the fill count moves around one mark.

The decision can reach the far end in two ways. An active-low request-to-send line is driven from the paused state when hardware line flow control is on. When that is off, the line follows a software-written modem bit. Separately, one-cycle requests ask a character transmitter to send a pause or resume character. These requests always alternate.

Both marks are held in one 8-bit setup register. The register accepts a write only while two configuration qualifiers are both high. It is always readable.

Top module: `rxfc_hyst`

## Requirements
- R1: After reset the setup register reads 0x00, `rts_n` is 0 (far end may send), and both `xoff_req` and `xon_req` are 0.
- R2: A write with `cfg_wr` high while `feat_en` and `bank_sel` are both 1 is visible on `cfg_rd` one cycle later.
- R3: A write while `feat_en` or `bank_sel` is 0 is ignored: `cfg_rd` keeps its previous value.
- R4: Bits [3:0] of the register hold the stop mark and bits [7:4] hold the go mark. Each mark is compared with the fill count as field value × 4, giving 0 to 60.
- R5: With `auto_rts` = 1, `rts_n` is 1 in the cycle after a clock edge at which `fifo_level` ≥ stop mark.
- R6: With `auto_rts` = 1, `rts_n` is 0 in the cycle after an edge at which `fifo_level` ≤ go mark and `fifo_level` < stop mark.
- R7: With `auto_rts` = 1 and the fill count strictly between the go mark and the stop mark, `rts_n` keeps the paused/running state from the previous edge.
- R8: Hardware does not check the order of the marks. When the fill count is both ≥ stop mark and ≤ go mark, the stop condition wins and the block is paused.
- R9: With `auto_rts` = 0, `rts_n` equals the inverse of `mcr_rts` one cycle later, whatever the fill count.
- R10: With `sw_flow` = 1, `xoff_req` pulses for one cycle when the block is paused and the last request was a resume (or none since reset). `xon_req` pulses for one cycle when the block is running and the last request was a pause.
- R11: `xoff_req` and `xon_req` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the setup register |
| cfg_wdata | input | 8 | Write data: [7:4] go mark, [3:0] stop mark |
| feat_en | input | 1 | Enhanced-feature qualifier for writes |
| bank_sel | input | 1 | Register-bank qualifier for writes |
| cfg_rd | output | 8 | Current setup register contents |
| fifo_level | input | 7 | Receive buffer fill count, 0 to 64 |
| auto_rts | input | 1 | Drive `rts_n` from the hysteresis state |
| sw_flow | input | 1 | Enable pause/resume character requests |
| mcr_rts | input | 1 | Software request-to-send bit, used when `auto_rts` is 0 |
| rts_n | output | 1 | Active-low request-to-send |
| xoff_req | output | 1 | One-cycle request to send a pause character |
| xon_req | output | 1 | One-cycle request to send a resume character |

## Verification
The hardest case to reach from the ports is the hold band. Its result depends on the direction from which the fill count entered the band, so a single level tells nothing. The bench therefore walks the fill count from 0 up to 64 and back down to 0 for each of the 256 settings of the register, including reversed and equal marks. Every point of the band is thus entered once from below and once from above. A bench-side model of the paused state and of the last request supplies the expected value at every step.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  // Result of comparing the fill count with both marks
  typedef struct packed {
    logic at_stop;   // level >= stop mark
    logic at_go;     // level <= go mark
  } rxfc_cmp_t;

  // Which software request was issued most recently
  typedef enum logic {
    LAST_RESUME = 1'b0,
    LAST_PAUSE  = 1'b1
  } rxfc_last_e;

endpackage

// File: rtl/rxfc_cfg_reg.sv
module rxfc_cfg_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             feat_en,
  input  logic             bank_sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);

  logic wr_ok;

  assign wr_ok = wr & feat_en & bank_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_ok) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
  import rxfc_pkg::*;
#(
  parameter int FLD_W      = 4,
  parameter int STEP_SHIFT = 2,
  parameter int LVL_W      = 7
) (
  input  logic [2*FLD_W-1:0] cfg,
  input  logic [LVL_W-1:0]   level,
  output rxfc_cmp_t          cmp
);

  localparam int NMARK = 2;   // index 0: stop mark, index 1: go mark

  logic [LVL_W-1:0] mark [NMARK];

  for (genvar g = 0; g < NMARK; g++) begin : g_mark
    assign mark[g] = LVL_W'({cfg[g*FLD_W +: FLD_W], {STEP_SHIFT{1'b0}}});
  end

  assign cmp.at_stop = (level >= mark[0]);
  assign cmp.at_go   = (level <= mark[1]);

endmodule

// File: rtl/rxfc_flow_fsm.sv
module rxfc_flow_fsm
  import rxfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rxfc_cmp_t cmp,
  input  logic      auto_rts,
  input  logic      sw_flow,
  input  logic      mcr_rts,
  output logic      rts_n,
  output logic      xoff_req,
  output logic      xon_req
);

  logic       paused_q;
  logic       paused_d;
  rxfc_last_e last_q;
  logic       send_pause;
  logic       send_resume;

  // Stop condition has priority over the go condition; otherwise hold
  always_comb begin
    if (cmp.at_stop) begin
      paused_d = 1'b1;
    end else if (cmp.at_go) begin
      paused_d = 1'b0;
    end else begin
      paused_d = paused_q;
    end
  end

  assign send_pause  = sw_flow &  paused_d & (last_q == LAST_RESUME);
  assign send_resume = sw_flow & ~paused_d & (last_q == LAST_PAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused_q <= 1'b0;
      last_q   <= LAST_RESUME;
      rts_n    <= 1'b0;
      xoff_req <= 1'b0;
      xon_req  <= 1'b0;
    end else begin
      paused_q <= paused_d;
      rts_n    <= auto_rts ? paused_d : ~mcr_rts;
      xoff_req <= send_pause;
      xon_req  <= send_resume;
      if (send_pause) begin
        last_q <= LAST_PAUSE;
      end else if (send_resume) begin
        last_q <= LAST_RESUME;
      end
    end
  end

endmodule

// File: rtl/rxfc_hyst.sv
module rxfc_hyst
  import rxfc_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int FLD_W      = 4,
  parameter int STEP_SHIFT = 2,
  parameter int LVL_W      = $clog2(DEPTH + 1),
  parameter int CFG_W      = 2 * FLD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             feat_en,
  input  logic             bank_sel,
  output logic [CFG_W-1:0] cfg_rd,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             auto_rts,
  input  logic             sw_flow,
  input  logic             mcr_rts,
  output logic             rts_n,
  output logic             xoff_req,
  output logic             xon_req
);

  rxfc_cmp_t cmp;

  rxfc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .feat_en  (feat_en),
    .bank_sel (bank_sel),
    .wdata    (cfg_wdata),
    .q        (cfg_rd)
  );

  rxfc_thresh #(
    .FLD_W      (FLD_W),
    .STEP_SHIFT (STEP_SHIFT),
    .LVL_W      (LVL_W)
  ) u_thr (
    .cfg   (cfg_rd),
    .level (fifo_level),
    .cmp   (cmp)
  );

  rxfc_flow_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cmp      (cmp),
    .auto_rts (auto_rts),
    .sw_flow  (sw_flow),
    .mcr_rts  (mcr_rts),
    .rts_n    (rts_n),
    .xoff_req (xoff_req),
    .xon_req  (xon_req)
  );

endmodule

// File: rtl/rxfc_hyst_chk.sv
module rxfc_hyst_chk #(
  parameter int FLD_W      = 4,
  parameter int STEP_SHIFT = 2,
  parameter int LVL_W      = 7,
  parameter int CFG_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             feat_en,
  input logic             bank_sel,
  input logic [CFG_W-1:0] cfg_rd,
  input logic [LVL_W-1:0] fifo_level,
  input logic             auto_rts,
  input logic             mcr_rts,
  input logic             rts_n,
  input logic             xoff_req,
  input logic             xon_req
);

  logic [LVL_W-1:0] stop_lvl;
  logic [LVL_W-1:0] go_lvl;

  assign stop_lvl = LVL_W'({cfg_rd[FLD_W-1:0], {STEP_SHIFT{1'b0}}});
  assign go_lvl   = LVL_W'({cfg_rd[2*FLD_W-1:FLD_W], {STEP_SHIFT{1'b0}}});

  AST_WR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && feat_en && bank_sel) |=> (cfg_rd == $past(cfg_wdata))); // R2

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && feat_en && bank_sel) |=> $stable(cfg_rd)); // R3

  AST_STOP_LINE: assert property (@(posedge clk) disable iff (rst)
    (auto_rts && fifo_level >= stop_lvl) |=> rts_n); // R5

  AST_GO_LINE: assert property (@(posedge clk) disable iff (rst)
    (auto_rts && fifo_level < stop_lvl && fifo_level <= go_lvl) |=> !rts_n); // R6

  AST_MANUAL_LINE: assert property (@(posedge clk) disable iff (rst)
    !auto_rts |=> (rts_n == !$past(mcr_rts))); // R9

  AST_NO_BOTH_REQ: assert property (@(posedge clk) disable iff (rst)
    !(xoff_req && xon_req)); // R11

  AST_PAUSE_ONE_CYC: assert property (@(posedge clk) disable iff (rst)
    xoff_req |=> !xoff_req); // R11

  AST_RESUME_ONE_CYC: assert property (@(posedge clk) disable iff (rst)
    xon_req |=> !xon_req); // R11

endmodule

bind rxfc_hyst rxfc_hyst_chk #(
  .FLD_W      (FLD_W),
  .STEP_SHIFT (STEP_SHIFT),
  .LVL_W      (LVL_W),
  .CFG_W      (CFG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .feat_en    (feat_en),
  .bank_sel   (bank_sel),
  .cfg_rd     (cfg_rd),
  .fifo_level (fifo_level),
  .auto_rts   (auto_rts),
  .mcr_rts    (mcr_rts),
  .rts_n      (rts_n),
  .xoff_req   (xoff_req),
  .xon_req    (xon_req)
);

// File: tb/rxfc_hyst_bench.sv
`timescale 1ns/1ps
module rxfc_hyst_bench;

  localparam int LVL_W = 7;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic       feat_en;
  logic       bank_sel;
  logic [7:0] cfg_rd;
  logic [LVL_W-1:0] fifo_level;
  logic       auto_rts;
  logic       sw_flow;
  logic       mcr_rts;
  logic       rts_n;
  logic       xoff_req;
  logic       xon_req;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench-side model state
  logic [7:0] m_cfg;
  logic       m_paused;
  logic       m_last_pause;
  logic       m_rts;
  logic       m_xoff;
  logic       m_xon;

  always #2.5 clk = ~clk;

  rxfc_hyst u_rxfc_hyst (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .feat_en    (feat_en),
    .bank_sel   (bank_sel),
    .cfg_rd     (cfg_rd),
    .fifo_level (fifo_level),
    .auto_rts   (auto_rts),
    .sw_flow    (sw_flow),
    .mcr_rts    (mcr_rts),
    .rts_n      (rts_n),
    .xoff_req   (xoff_req),
    .xon_req    (xon_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: model follows the inputs present at the edge
  task automatic tick();
    int stop_l;
    int go_l;
    logic nxt;
    @(posedge clk);
    stop_l = int'(m_cfg[3:0]) * 4;
    go_l   = int'(m_cfg[7:4]) * 4;
    if (int'(fifo_level) >= stop_l)   nxt = 1'b1;
    else if (int'(fifo_level) <= go_l) nxt = 1'b0;
    else                               nxt = m_paused;
    m_rts  = auto_rts ? nxt : ~mcr_rts;
    m_xoff = sw_flow & nxt & ~m_last_pause;
    m_xon  = sw_flow & ~nxt & m_last_pause;
    if (m_xoff) m_last_pause = 1'b1;
    if (m_xon)  m_last_pause = 1'b0;
    m_paused = nxt;
    if (cfg_wr && feat_en && bank_sel) m_cfg = cfg_wdata;
    @(negedge clk);
  endtask

  task automatic check_outs(input string rts_tag);
    chk(rts_tag, int'(rts_n), int'(m_rts));
    chk("R10 xoff_req", int'(xoff_req), int'(m_xoff));
    chk("R10 xon_req", int'(xon_req), int'(m_xon));
    chk("R11 both requests", int'(xoff_req && xon_req), 0);
  endtask

  function automatic string tag_for(input int lvl, input logic [7:0] c);
    int stop_l;
    int go_l;
    stop_l = int'(c[3:0]) * 4;
    go_l   = int'(c[7:4]) * 4;
    if (lvl >= stop_l && lvl <= go_l) return "R8 rts_n";
    if (lvl == stop_l)                return "R4 R5 rts_n";
    if (lvl >= stop_l)                return "R5 rts_n";
    if (lvl <= go_l)                  return "R6 rts_n";
    return "R7 rts_n";
  endfunction

  task automatic write_cfg(input logic [7:0] d, input logic fe, input logic bs, input string tag);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    feat_en   = fe;
    bank_sel  = bs;
    tick();
    cfg_wr    = 1'b0;
    chk(tag, int'(cfg_rd), int'(m_cfg));
  endtask

  task automatic sweep(input logic [7:0] c);
    write_cfg(c, 1'b1, 1'b1, "R2 write");
    for (int l = 0; l <= 64; l++) begin
      fifo_level = LVL_W'(l);
      tick();
      check_outs(tag_for(l, m_cfg));
    end
    for (int l = 64; l >= 0; l--) begin
      fifo_level = LVL_W'(l);
      tick();
      check_outs(tag_for(l, m_cfg));
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; feat_en = 1'b0; bank_sel = 1'b0;
    fifo_level = '0; auto_rts = 1'b0; sw_flow = 1'b0; mcr_rts = 1'b1;
    m_cfg = '0; m_paused = 1'b0; m_last_pause = 1'b0;
    m_rts = 1'b0; m_xoff = 1'b0; m_xon = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 cfg_rd", int'(cfg_rd), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 xoff_req", int'(xoff_req), 0);
    chk("R1 xon_req", int'(xon_req), 0);

    // R2 / R3: write gating over all qualifier combinations
    write_cfg(8'h3C, 1'b1, 1'b1, "R2 gated write accepted");
    write_cfg(8'h55, 1'b0, 1'b0, "R3 write ignored (0,0)");
    write_cfg(8'h66, 1'b1, 1'b0, "R3 write ignored (1,0)");
    write_cfg(8'h77, 1'b0, 1'b1, "R3 write ignored (0,1)");
    chk("R3 value kept", int'(cfg_rd), 8'h3C);

    // R9: manual line with auto off, level above stop mark
    fifo_level = 7'd60;
    mcr_rts = 1'b1; tick(); check_outs("R9 rts_n manual");
    mcr_rts = 1'b0; tick(); check_outs("R9 rts_n manual");
    chk("R9 rts_n high", int'(rts_n), 1);
    mcr_rts = 1'b1; fifo_level = 7'd0; tick(); check_outs("R9 rts_n manual");
    chk("R9 rts_n low", int'(rts_n), 0);

    // R4: exact mark boundaries, stop 48, go 12
    auto_rts = 1'b1;
    fifo_level = 7'd47; tick(); chk("R4 below stop mark", int'(rts_n), 0);
    fifo_level = 7'd48; tick(); chk("R4 at stop mark", int'(rts_n), 1);
    fifo_level = 7'd13; tick(); chk("R4 R7 above go mark", int'(rts_n), 1);
    fifo_level = 7'd12; tick(); chk("R4 at go mark", int'(rts_n), 0);

    // R10: software requests with manual line
    auto_rts = 1'b0; sw_flow = 1'b1; mcr_rts = 1'b1;
    sweep(8'h3C);
    // line flow only, no requests
    auto_rts = 1'b1; sw_flow = 1'b0;
    sweep(8'h3C);

    // Full sweep of every mark pair with both mechanisms on
    sw_flow = 1'b1;
    for (int g = 0; g < 16; g++) begin
      for (int s = 0; s < 16; s++) begin
        sweep({4'(g), 4'(s)});
      end
    end

    summary();
    $finish;
  end

endmodule